// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Sideband Transport

This block moves a stream of beats from one clock domain to another clock that has no relation to the first. Each beat is accepted on a write-side stream port with a valid/ready handshake. The beat carries a 64-bit data word, a byte-enable mask, an end-of-frame flag, an 8-bit source tag, an 8-bit routing tag and a 1-bit user flag. All of these fields are stored together in a 32-entry buffer. On the read side they come back out together through a short register pipeline, ready for timing closure next to the consumer.

The write and read positions cross between domains as Gray codes through two-flop synchronizers. Full is judged on the write side and empty on the read side. A single asynchronous reset input is synchronized separately into each domain. It clears every pointer and pipeline stage, so anything the buffer held is lost.

An optional frame mode publishes a frame to the reader only once its last beat is written. In that mode a frame whose closing user flag matches a configurable value under a mask can be discarded. A further option drops the rest of a frame that meets a full buffer. Both options are off by default, and in that case beats stream straight through.

Top module: `axis_cdc_fifo`

## Requirements
- R1: While reset is applied, `s_tready` and `m_tvalid` are both low. Within a few write clocks after release, an empty FIFO raises `s_tready`.
- R2: With the default configuration, every accepted beat reappears at the read port once, in acceptance order. Its data, keep (8 bits, one per data byte), last, id (8 bits) and dest (8 bits) are unchanged, and its user bit is 0 on beats that were sent with user 0.
- R3: Stored occupancy never exceeds DEPTH. With the sink stalled from an empty state, exactly DEPTH + OUT_STAGES beats (34 by default) are accepted, after which `s_tready` stays low.
- R4: Once `m_tvalid` is high it stays high, and the whole payload stays stable, until a cycle in which `m_tready` is high.
- R5: Applying reset while beats are held because the sink stalls discards them. No beat appears on the read port after release, even with `m_tready` high.
- R6: Order and content per R2 hold when the source inserts gaps, when the sink withholds ready intermittently, and when both do so at once.
- R7: A user bit of 1 on the last beat of a frame appears on the last output beat of that frame.
- R8: With frame mode off, frames whose last-beat user equals the bad-frame value (1 under mask 1) are delivered unchanged rather than dropped.
- R9: In frame mode, no beat of a frame reaches the read port before its last beat has been accepted.
- R10: In frame mode with bad-frame dropping on, a frame whose last-beat user matches the bad value under the mask is removed entirely. The frames before and after it arrive intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst | input | 1 | Asynchronous reset, active high, for both domains |
| wr_clk | input | 1 | Write-side clock |
| s_tdata | input | 64 | Write beat data |
| s_tkeep | input | 8 | Write byte enables |
| s_tvalid | input | 1 | Write beat valid |
| s_tready | output | 1 | Write beat accepted when high with valid |
| s_tlast | input | 1 | Last beat of frame |
| s_tid | input | 8 | Source tag |
| s_tdest | input | 8 | Routing tag |
| s_tuser | input | 1 | User flag |
| rd_clk | input | 1 | Read-side clock |
| m_tdata | output | 64 | Read beat data |
| m_tkeep | output | 8 | Read byte enables |
| m_tvalid | output | 1 | Read beat valid |
| m_tready | input | 1 | Consumer ready |
| m_tlast | output | 1 | Last beat of frame |
| m_tid | output | 8 | Source tag |
| m_tdest | output | 8 | Routing tag |
| m_tuser | output | 1 | User flag |

## Verification
The hardest state to reach from the ports is a completely full buffer whose full flag depends on a read position that has already crossed back through the synchronizers, with the output pipeline loaded too. The bench holds ready low from an empty state and streams for hundreds of write clocks. It then counts the accepted beats exactly and checks that the head beat does not change. A second hard case is reset arriving while that stored content is still pending. The bench reaches it by filling under a stall, pulsing reset, and then watching an eager sink for stray beats. Frame-mode withholding and discard run on a second instance with frame mode enabled.

// File: rtl/axis_cdc_fifo.sv
module axis_cdc_fifo #(
  parameter int DEPTH      = 32,
  parameter int DATA_W     = 64,
  parameter bit KEEP_ON    = (DATA_W > 8),
  parameter int KEEP_W     = (DATA_W + 7) / 8,
  parameter int ID_W       = 8,
  parameter int DEST_W     = 8,
  parameter int USER_W     = 1,
  parameter int OUT_STAGES = 2,
  parameter bit FRAME_MODE = 0,
  parameter int BAD_VALUE  = 1,
  parameter int BAD_MASK   = 1,
  parameter bit DROP_BAD   = 0,
  parameter bit DROP_FULL  = 0
) (
  input  logic              arst,
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [KEEP_W-1:0] s_tkeep,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  input  logic [ID_W-1:0]   s_tid,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic [USER_W-1:0] s_tuser,
  input  logic              rd_clk,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic [ID_W-1:0]   m_tid,
  output logic [DEST_W-1:0] m_tdest,
  output logic [USER_W-1:0] m_tuser
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int W  = DATA_W + KEEP_W + 1 + ID_W + DEST_W + USER_W;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];

  // reset synchronizers: assert at once, release on the local clock
  logic [1:0] wrst_q, rrst_q;
  logic       wrst, rrst;

  always_ff @(posedge wr_clk or posedge arst)
    if (arst) wrst_q <= 2'b11;
    else      wrst_q <= {wrst_q[0], 1'b0};

  always_ff @(posedge rd_clk or posedge arst)
    if (arst) rrst_q <= 2'b11;
    else      rrst_q <= {rrst_q[0], 1'b0};

  assign wrst = wrst_q[1];
  assign rrst = rrst_q[1];

  // write domain
  logic [PW-1:0] wcur, wcommit, wpub, wpub_g;
  logic [PW-1:0] rsync1, rsync2, rd_bin_w, wfill;
  logic          wdropping, full, wfire, store, bad_frame;
  logic [W-1:0]  s_word;

  assign s_word    = {s_tdata, s_tkeep, s_tlast, s_tid, s_tdest, s_tuser};
  assign rd_bin_w  = gray2bin(rsync2);
  assign wfill     = wcur - rd_bin_w;
  assign full      = (wfill == PW'(DEPTH));
  assign s_tready  = !wrst && (!full || (FRAME_MODE && DROP_FULL));
  assign wfire     = s_tvalid && s_tready;
  assign store     = wfire && !wdropping && !full;
  assign bad_frame = ((s_tuser ^ USER_W'(BAD_VALUE)) & USER_W'(BAD_MASK)) == '0;

  always_ff @(posedge wr_clk)
    if (store) mem[wcur[AW-1:0]] <= s_word;

  always_ff @(posedge wr_clk or posedge wrst) begin
    if (wrst) begin
      wcur      <= '0;
      wcommit   <= '0;
      wpub      <= '0;
      wpub_g    <= '0;
      rsync1    <= '0;
      rsync2    <= '0;
      wdropping <= 1'b0;
    end else begin
      if (wfire) begin
        if (wdropping) begin
          if (s_tlast) wdropping <= 1'b0;
        end else if (full) begin
          wcur      <= wcommit;
          wdropping <= !s_tlast;
        end else if (!FRAME_MODE || s_tlast) begin
          if (FRAME_MODE && DROP_BAD && bad_frame) begin
            wcur <= wcommit;
          end else begin
            wcur    <= wcur + 1'b1;
            wcommit <= wcur + 1'b1;
          end
        end else begin
          wcur <= wcur + 1'b1;
        end
      end
      // published pointer walks one step per clock so its Gray code moves one bit at a time
      if (wpub != wcommit) wpub <= wpub + 1'b1;
      wpub_g <= bin2gray(wpub);
      rsync1 <= rpub_g;
      rsync2 <= rsync1;
    end
  end

  // read domain
  logic [PW-1:0] rptr, rpub_g, wsync1, wsync2, wr_bin_r;
  logic          empty, rd_en;
  logic [OUT_STAGES-1:0] st_v;
  logic [OUT_STAGES:0]   st_rdy;
  logic [W-1:0]          st_d [OUT_STAGES];

  assign wr_bin_r = gray2bin(wsync2);
  assign empty    = (rptr == wr_bin_r);
  assign rd_en    = !empty && st_rdy[0];
  assign st_rdy[OUT_STAGES] = m_tready;

  always_ff @(posedge rd_clk or posedge rrst) begin
    if (rrst) begin
      rptr   <= '0;
      rpub_g <= '0;
      wsync1 <= '0;
      wsync2 <= '0;
    end else begin
      rptr   <= rptr + PW'(rd_en);
      rpub_g <= bin2gray(rptr);
      wsync1 <= wpub_g;
      wsync2 <= wsync1;
    end
  end

  genvar gi;
  for (gi = 0; gi < OUT_STAGES; gi++) begin : g_stage
    logic         v;
    logic [W-1:0] d;
    logic         v_in;
    logic [W-1:0] d_in;

    if (gi == 0) begin : g_head
      assign v_in = !empty;
      assign d_in = mem[rptr[AW-1:0]];
    end else begin : g_tail
      assign v_in = st_v[gi-1];
      assign d_in = st_d[gi-1];
    end

    always_ff @(posedge rd_clk or posedge rrst)
      if (rrst)             v <= 1'b0;
      else if (st_rdy[gi])  v <= v_in;

    always_ff @(posedge rd_clk)
      if (st_rdy[gi] && v_in) d <= d_in;

    assign st_v[gi]   = v;
    assign st_d[gi]   = d;
    assign st_rdy[gi] = !v || st_rdy[gi+1];
  end

  logic [KEEP_W-1:0] keep_raw;

  assign m_tvalid = st_v[OUT_STAGES-1];
  assign {m_tdata, keep_raw, m_tlast, m_tid, m_tdest, m_tuser} = st_d[OUT_STAGES-1];
  assign m_tkeep  = KEEP_ON ? keep_raw : '1;

endmodule

// File: rtl/axis_cdc_fifo_chk.sv
module axis_cdc_fifo_chk #(
  parameter int DEPTH  = 32,
  parameter int PW     = 6,
  parameter int DATA_W = 64,
  parameter int USER_W = 1
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wrst,
  input logic              rrst,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast,
  input logic [USER_W-1:0] m_tuser,
  input logic [PW-1:0]     wcur,
  input logic [PW-1:0]     rd_bin_w,
  input logic [PW-1:0]     wr_bin_r,
  input logic [PW-1:0]     rptr,
  input logic [PW-1:0]     wpub_g,
  input logic [PW-1:0]     rpub_g
);

  assert_reset_quiet_R1: assert property (@(posedge rd_clk)
    rrst |-> !m_tvalid);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wrst)
    PW'(wcur - rd_bin_w) <= PW'(DEPTH));

  assert_no_underflow_R2: assert property (@(posedge rd_clk) disable iff (rrst)
    PW'(wr_bin_r - rptr) <= PW'(DEPTH));

  assert_wr_gray_step_R2: assert property (@(posedge wr_clk) disable iff (wrst)
    $countones(wpub_g ^ $past(wpub_g)) <= 1);

  assert_rd_gray_step_R2: assert property (@(posedge rd_clk) disable iff (rrst)
    $countones(rpub_g ^ $past(rpub_g)) <= 1);

  assert_hold_payload_R4: assert property (@(posedge rd_clk) disable iff (rrst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));

endmodule

bind axis_cdc_fifo axis_cdc_fifo_chk #(
  .DEPTH(DEPTH), .PW(PW), .DATA_W(DATA_W), .USER_W(USER_W)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst(wrst), .rrst(rrst),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tlast(m_tlast), .m_tuser(m_tuser),
  .wcur(wcur), .rd_bin_w(rd_bin_w), .wr_bin_r(wr_bin_r), .rptr(rptr),
  .wpub_g(wpub_g), .rpub_g(rpub_g)
);

// File: tb/axis_cdc_fifo_tb.sv
module axis_cdc_fifo_tb;
  localparam int DEPTH = 32;
  localparam int STG   = 2;

  logic arst = 0, wclk = 0, rclk = 0;
  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  logic [63:0] s_tdata = '0;  logic [7:0] s_tkeep = '0;
  logic s_tvalid = 0, s_tlast = 0;  logic [7:0] s_tid = '0, s_tdest = '0;
  logic [0:0] s_tuser = '0;  logic s_tready;
  logic [63:0] m_tdata; logic [7:0] m_tkeep; logic m_tvalid, m_tlast;
  logic m_tready = 0; logic [7:0] m_tid, m_tdest; logic [0:0] m_tuser;

  axis_cdc_fifo u_dut (
    .arst(arst), .wr_clk(wclk), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast), .s_tid(s_tid),
    .s_tdest(s_tdest), .s_tuser(s_tuser), .rd_clk(rclk), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .m_tid(m_tid), .m_tdest(m_tdest), .m_tuser(m_tuser));

  logic [63:0] f_s_tdata = '0; logic f_s_tvalid = 0, f_s_tlast = 0; logic [0:0] f_s_tuser = '0;
  logic f_s_tready;
  logic [63:0] f_m_tdata; logic [7:0] f_m_tkeep, f_m_tid, f_m_tdest; logic f_m_tvalid, f_m_tlast;
  logic [0:0] f_m_tuser;

  axis_cdc_fifo #(.FRAME_MODE(1), .DROP_BAD(1)) u_dut_frm (
    .arst(arst), .wr_clk(wclk), .s_tdata(f_s_tdata), .s_tkeep(8'hFF),
    .s_tvalid(f_s_tvalid), .s_tready(f_s_tready), .s_tlast(f_s_tlast), .s_tid(8'h00),
    .s_tdest(8'h00), .s_tuser(f_s_tuser), .rd_clk(rclk), .m_tdata(f_m_tdata),
    .m_tkeep(f_m_tkeep), .m_tvalid(f_m_tvalid), .m_tready(1'b1), .m_tlast(f_m_tlast),
    .m_tid(f_m_tid), .m_tdest(f_m_tdest), .m_tuser(f_m_tuser));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int flen(input int f); return 1 + (f * 7) % 11; endfunction
  function automatic logic [63:0] edata(input int n);
    return {32'(n) ^ 32'hA5A5_0000, 32'(n * 3 + 7)};
  endfunction
  function automatic logic [7:0] ekeep(input int n); return 8'(n * 5 + 1); endfunction

  // source, write domain
  int tx_n = 0, tx_f = 0, tx_pos = 0, tx_flim = 0, src_mode = 0;
  bit tx_pend = 0;
  logic [15:0] wl = 16'hACE1;

  always @(negedge wclk) begin
    bit gate;
    wl = {wl[14:0], wl[15] ^ wl[13] ^ wl[12] ^ wl[10]};
    if (tx_pend) begin
      tx_n++;
      if (tx_pos == flen(tx_f) - 1) begin tx_pos = 0; tx_f++; end
      else tx_pos++;
    end
    gate = (src_mode == 0) ? 1'b1 : (src_mode == 1) ? (wl[0] | wl[5]) : wl[2];
    s_tvalid = (tx_f < tx_flim) && gate;
    s_tdata  = edata(tx_n);
    s_tkeep  = ekeep(tx_n);
    s_tlast  = (tx_pos == flen(tx_f) - 1);
    s_tid    = 8'(tx_f);
    s_tdest  = 8'(tx_f * 3 + 1);
    s_tuser  = s_tlast & 1'(tx_f);
    tx_pend  = s_tvalid && s_tready;
  end

  // sink, read domain
  int rx_n = 0, rx_f = 0, rx_pos = 0, snk_mode = 0, unexpected = 0, rx_uframes = 0;
  string phase_req = "R2";
  logic [15:0] rl = 16'h1D0F;

  always @(negedge rclk) begin
    bit lst, ok;
    rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
    m_tready = (snk_mode == 0) ? 1'b1 : (snk_mode == 1) ? (rl[1] | rl[4]) :
               (snk_mode == 2) ? rl[3] : 1'b0;
    if (m_tvalid && m_tready) begin
      if (rx_n >= tx_n) begin
        unexpected++;
        check(0, "R5", "beat with nothing outstanding", m_tdata, 64'h0);
      end else begin
        lst = (rx_pos == flen(rx_f) - 1);
        ok = (m_tdata == edata(rx_n)) && (m_tkeep == ekeep(rx_n)) && (m_tlast == lst) &&
             (m_tid == 8'(rx_f)) && (m_tdest == 8'(rx_f * 3 + 1)) && (lst || m_tuser == 1'b0);
        check(ok, phase_req, "beat content", m_tdata, edata(rx_n));
        if (lst) begin
          check(m_tuser == 1'(rx_f), "R7", "user on last beat", 64'(m_tuser), 64'(1'(rx_f)));
          if (m_tuser == 1'b1) rx_uframes++;
        end
        rx_n++;
        if (lst) begin rx_pos = 0; rx_f++; end
        else rx_pos++;
      end
    end
  end

  // frame-mode receiver
  int fr_cnt = 0;
  int fr_tag [16];
  bit fr_last [16];
  always @(negedge rclk) begin
    if (f_m_tvalid && fr_cnt < 16) begin
      fr_tag[fr_cnt]  = int'(f_m_tdata[7:0]);
      fr_last[fr_cnt] = f_m_tlast;
      fr_cnt++;
    end
  end

  task automatic fsend(input int tag, input bit last, input bit user);
    @(negedge wclk);
    f_s_tvalid = 1; f_s_tdata = 64'(tag); f_s_tlast = last; f_s_tuser = user;
    while (!f_s_tready) @(negedge wclk);
    @(negedge wclk);
    f_s_tvalid = 0;
  endtask

  task automatic wait_drain(input string req);
    int k = 0;
    while (!(tx_f == tx_flim && rx_n == tx_n) && k < 40000) begin
      @(negedge wclk); k++;
    end
    check(rx_n == tx_n, req, "all beats delivered", 64'(rx_n), 64'(tx_n));
  endtask

  task automatic run_phase(input int sm, input int km, input int frames, input string req);
    phase_req = req; src_mode = sm; snk_mode = km;
    tx_flim = tx_f + frames;
    wait_drain(req);
  endtask

  initial begin
    #(20 * 150000);
    check(0, "ALL", "watchdog expired", 64'(rx_n), 64'(tx_n));
    finish_up();
  end

  initial begin
    int base;
    logic [63:0] head;
    int exp_tags [5];
    exp_tags = '{1, 2, 3, 6, 7};
    #1 arst = 1;
    repeat (4) @(negedge wclk);
    check(s_tready == 0, "R1", "s_tready in reset", 64'(s_tready), 64'h0);
    check(m_tvalid == 0, "R1", "m_tvalid in reset", 64'(m_tvalid), 64'h0);
    arst = 0;
    repeat (6) @(negedge wclk);
    check(s_tready == 1, "R1", "s_tready after release", 64'(s_tready), 64'h1);
    check(m_tvalid == 0, "R1", "m_tvalid after release", 64'(m_tvalid), 64'h0);

    run_phase(0, 0, 30, "R2");
    check(rx_uframes == 15, "R8", "frames with user set delivered", 64'(rx_uframes), 64'd15);
    run_phase(1, 0, 30, "R6");
    run_phase(0, 1, 30, "R6");
    run_phase(2, 2, 30, "R6");
    run_phase(1, 1, 40, "R6");

    // long stall fills the buffer (R3, R4)
    snk_mode = 3; phase_req = "R3";
    repeat (5) @(negedge wclk);
    base = tx_n; src_mode = 0; tx_flim = tx_f + 30;
    repeat (300) @(negedge wclk);
    check(tx_n - base == DEPTH + STG, "R3", "beats accepted under stall", 64'(tx_n - base), 64'(DEPTH + STG));
    check(s_tready == 0, "R3", "s_tready when full", 64'(s_tready), 64'h0);
    @(negedge rclk);
    head = m_tdata;
    check(m_tvalid == 1 && head == edata(rx_n), "R4", "head beat presented", head, edata(rx_n));
    repeat (20) @(negedge rclk);
    check(m_tvalid == 1 && m_tdata == head, "R4", "head beat held", m_tdata, head);
    snk_mode = 0;
    wait_drain("R3");

    // reset with held content (R5)
    snk_mode = 3; phase_req = "R5";
    tx_flim = tx_f + 3;
    begin
      int k = 0;
      while (tx_f != tx_flim && k < 5000) begin @(negedge wclk); k++; end
    end
    repeat (40) @(negedge wclk);
    arst = 1;
    repeat (3) @(negedge wclk);
    arst = 0;
    rx_n = tx_n; rx_f = tx_f; rx_pos = 0; unexpected = 0;
    snk_mode = 0;
    repeat (100) @(negedge rclk);
    check(unexpected == 0 && m_tvalid == 0, "R5", "no output after reset", 64'(unexpected), 64'h0);
    run_phase(1, 2, 20, "R6");

    // frame mode on second instance (R9, R10)
    fsend(1, 0, 0);
    fsend(2, 0, 0);
    repeat (40) @(negedge wclk);
    check(fr_cnt == 0 && f_m_tvalid == 0, "R9", "partial frame withheld", 64'(fr_cnt), 64'h0);
    fsend(3, 1, 0);
    fsend(4, 0, 0);
    fsend(5, 1, 1);
    fsend(6, 0, 0);
    fsend(7, 1, 0);
    repeat (60) @(negedge wclk);
    check(fr_cnt == 5, "R10", "beats after bad frame drop", 64'(fr_cnt), 64'd5);
    for (int i = 0; i < 5; i++)
      check(fr_tag[i] == exp_tags[i], "R10", "surviving beat tag", 64'(fr_tag[i]), 64'(exp_tags[i]));
    check(fr_last[2] && fr_last[4] && !fr_last[0] && !fr_last[3], "R9", "frame boundaries",
          64'({fr_last[0], fr_last[2], fr_last[3], fr_last[4]}), 64'b0101);

    finish_up();
  end
endmodule